// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block judges one 512-byte chunk of a page read from NAND flash. It compares the 24-bit check code that was stored in the spare area with the 24-bit code just computed over the data. Each code is treated as two 12-bit halves. XORing the halves of the two codes gives two syndromes, `odd` and `even`. The block then sorts the chunk into one of four outcomes: clean, one flipped data bit that can be fixed, one flipped bit inside the check code itself, or damage it cannot fix. When the chunk engine has already marked the chunk as failed, the syndrome is not examined.

For a fixable data error the block reports the byte and bit to flip. It also corrects that byte as the chunk's data streams through a one-byte-per-cycle port. Running counts of corrected and failed chunks, and the largest bitflip count seen in any chunk (0 or 1), are kept across the chunks of a page. A page-start strobe clears them.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: Each code splits into halves. Code bits [11:0] are the lower half: byte 0 (bits [7:0]) plus the low nibble of byte 1. Code bits [23:12] are the upper half: the high nibble of byte 1 plus byte 2. The syndrome `odd` is stored lower XOR computed lower, and `even` is stored upper XOR computed upper.
- R2: When `odd` and `even` are both zero, the status is 0 (clean). Neither counter changes.
- R3: When `odd` equals the 12-bit complement of `even`, the status is 1 (data bit to fix). `err_byte` is `odd[11:3]` and `err_bit` is `odd[2:0]`. This covers the boundary offsets 0/0 and 511/7.
- R4: When the two syndromes are not complements of each other and `odd | even` has exactly one bit set, the status is 2 (check-code bit flipped). The streamed data is then left unchanged.
- R5: Every other non-zero syndrome gives status 3 (uncorrectable) and adds one to `failed_cnt`.
- R6: When `chunk_failed` is high together with `start`, the status is 3 and `failed_cnt` goes up by one, whatever the two codes are.
- R7: Statuses 1 and 2 each add one to `corrected_cnt`.
- R8: `max_flips` goes to 1 on any status 1 or 2 and stays at 1. `page_start` clears `max_flips`, `corrected_cnt` and `failed_cnt`. A chunk started in the same cycle as `page_start` is counted on top of the cleared values.
- R9: `done` is high exactly in the cycle after each `start`, and the status and offsets are valid in that cycle. A `start` in consecutive cycles gives `done` in consecutive cycles, each with its own result.
- R10: The stream output copies the input one cycle later. A byte whose `s_offset` equals the latest fix offset is XORed with `1 << err_bit`. This happens only while the most recent result is status 1. All other bytes pass through unchanged.
- R11: After reset, `done`, `m_valid`, `status`, both counters and `max_flips` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluate the codes presented this cycle |
| chunk_failed | input | 1 | Chunk engine already flagged this chunk as failed |
| stored_ecc | input | 24 | Check code read from the spare area, byte 0 in bits [7:0] |
| calc_ecc | input | 24 | Check code computed over the chunk data |
| page_start | input | 1 | Clear the page counters and maximum |
| done | output | 1 | Result valid (one cycle after start) |
| status | output | 2 | 0 clean, 1 data fixed, 2 check-code bit, 3 uncorrectable |
| err_byte | output | 9 | Byte offset to flip when status is 1 |
| err_bit | output | 3 | Bit offset to flip when status is 1 |
| corrected_cnt | output | 8 | Chunks with one corrected bitflip this page |
| failed_cnt | output | 8 | Uncorrectable chunks this page |
| max_flips | output | 1 | Largest bitflip count in one chunk this page |
| s_valid | input | 1 | Stream byte valid |
| s_offset | input | 9 | Byte offset of the stream byte within the chunk |
| s_data | input | 8 | Stream byte in |
| m_valid | output | 1 | Stream byte out valid |
| m_data | output | 8 | Stream byte out, corrected where needed |

## Verification
Every result is one register away from its stimulus. The status, the offsets, `done`, the counters and `max_flips` are all due in the cycle after `start` or `page_start`. A streamed byte appears on `m_data` in the cycle after it was offered. The bench drives inputs on the falling edge and holds them across exactly one rising edge. It reads the outputs on the following falling edge, after that one register update. For back-to-back starts it reads one result per falling edge. It also confirms that `done` has dropped one cycle later.

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer #(
  parameter int CNT_W  = 8,
  parameter int OFF_W  = 9,
  parameter int BIT_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 chunk_failed,
  input  logic [2*(OFF_W+BIT_W)-1:0] stored_ecc,
  input  logic [2*(OFF_W+BIT_W)-1:0] calc_ecc,
  input  logic                 page_start,
  output logic                 done,
  output logic [1:0]           status,
  output logic [OFF_W-1:0]     err_byte,
  output logic [BIT_W-1:0]     err_bit,
  output logic [CNT_W-1:0]     corrected_cnt,
  output logic [CNT_W-1:0]     failed_cnt,
  output logic                 max_flips,
  input  logic                 s_valid,
  input  logic [OFF_W-1:0]     s_offset,
  input  logic [(1<<BIT_W)-1:0] s_data,
  output logic                 m_valid,
  output logic [(1<<BIT_W)-1:0] m_data
);
  localparam int HALF_W = OFF_W + BIT_W;
  localparam int CODE_W = 2 * HALF_W;
  localparam int DATA_W = 1 << BIT_W;

  localparam logic [1:0] ST_CLEAN  = 2'd0;
  localparam logic [1:0] ST_DATA   = 2'd1;
  localparam logic [1:0] ST_CODE   = 2'd2;
  localparam logic [1:0] ST_UNCORR = 2'd3;

  logic [HALF_W-1:0] odd_syn, even_syn;
  logic [1:0]        verdict;
  logic              flip_now, fail_now, fix_en, hit;
  logic [DATA_W-1:0] flip_mask;

  assign odd_syn  = stored_ecc[HALF_W-1:0]      ^ calc_ecc[HALF_W-1:0];
  assign even_syn = stored_ecc[CODE_W-1:HALF_W] ^ calc_ecc[CODE_W-1:HALF_W];

  always_comb begin
    if (chunk_failed)                               verdict = ST_UNCORR;
    else if (odd_syn == '0 && even_syn == '0)       verdict = ST_CLEAN;
    else if (odd_syn == ~even_syn)                  verdict = ST_DATA;
    else if ($countones(odd_syn | even_syn) == 1)   verdict = ST_CODE;
    else                                            verdict = ST_UNCORR;
  end

  assign flip_now = start && (verdict == ST_DATA || verdict == ST_CODE);
  assign fail_now = start && (verdict == ST_UNCORR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= ST_CLEAN;
      err_byte <= '0;
      err_bit  <= '0;
      fix_en   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        status <= verdict;
        if (verdict == ST_DATA) begin
          fix_en   <= 1'b1;
          err_byte <= odd_syn[HALF_W-1:BIT_W];
          err_bit  <= odd_syn[BIT_W-1:0];
        end else begin
          fix_en   <= 1'b0;
          err_byte <= '0;
          err_bit  <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corrected_cnt <= '0;
      failed_cnt    <= '0;
      max_flips     <= 1'b0;
    end else if (page_start) begin
      corrected_cnt <= CNT_W'(flip_now);
      failed_cnt    <= CNT_W'(fail_now);
      max_flips     <= flip_now;
    end else begin
      if (flip_now) corrected_cnt <= corrected_cnt + CNT_W'(1);
      if (fail_now) failed_cnt    <= failed_cnt + CNT_W'(1);
      if (flip_now) max_flips     <= 1'b1;
    end
  end

  assign flip_mask = DATA_W'(1) << err_bit;
  assign hit       = s_valid && fix_en && (s_offset == err_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= s_valid;
      m_data  <= hit ? (s_data ^ flip_mask) : s_data;
    end
  end

  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_fail_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !page_start && chunk_failed |=> failed_cnt == CNT_W'($past(failed_cnt) + CNT_W'(1)));
  p_max_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    max_flips && !page_start |=> max_flips);
  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !(fix_en && s_offset == err_byte) |=> m_valid && m_data == $past(s_data));
  p_one_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && fix_en && s_offset == err_byte |=> $countones(m_data ^ $past(s_data)) == 1);
  p_code_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == ST_CODE |-> !fix_en);
endmodule

// File: tb/tb_ecc_syndrome_fixer.sv
`timescale 1ns/1ps
module tb_ecc_syndrome_fixer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, chunk_failed = 0, page_start = 0;
  logic [23:0] stored_ecc = '0, calc_ecc = '0;
  logic done, max_flips, m_valid;
  logic [1:0] status;
  logic [8:0] err_byte;
  logic [2:0] err_bit;
  logic [7:0] corrected_cnt, failed_cnt, m_data;
  logic s_valid = 0;
  logic [8:0] s_offset = '0;
  logic [7:0] s_data = '0;

  int tests = 0, fails = 0;
  int exp_corr = 0, exp_fail = 0, exp_max = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ecc_syndrome_fixer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chunk_failed(chunk_failed),
    .stored_ecc(stored_ecc), .calc_ecc(calc_ecc), .page_start(page_start),
    .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
    .corrected_cnt(corrected_cnt), .failed_cnt(failed_cnt), .max_flips(max_flips),
    .s_valid(s_valid), .s_offset(s_offset), .s_data(s_data),
    .m_valid(m_valid), .m_data(m_data));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pack(input logic [11:0] up, input logic [11:0] lo);
    logic [7:0] b0, b1, b2;
    b0 = lo[7:0];
    b1 = {up[3:0], lo[11:8]};
    b2 = up[11:4];
    return {b2, b1, b0};
  endfunction

  task automatic issue(input logic [23:0] st, input logic [23:0] cc, input bit fl);
    @(negedge clk);
    stored_ecc = st; calc_ecc = cc; chunk_failed = fl; start = 1;
    @(negedge clk);
    start = 0; chunk_failed = 0;
  endtask

  task automatic expect_result(input string req, input int st, input int eb, input int bt);
    if (st == 1 || st == 2) begin exp_corr++; exp_max = 1; end
    if (st == 3) exp_fail++;
    check({req, " done"}, done, 1);
    check({req, " status"}, status, st);
    if (st == 1) begin
      check({req, " byte"}, err_byte, eb);
      check({req, " bit"}, err_bit, bt);
    end
    check("R7 corrected count", corrected_cnt, exp_corr);
    check("R5 failed count", failed_cnt, exp_fail);
    check("R8 max flips", max_flips, exp_max);
  endtask

  task automatic stream(input string req, input int off, input int din, input int dout);
    @(negedge clk);
    s_valid = 1; s_offset = off[8:0]; s_data = din[7:0];
    @(negedge clk);
    s_valid = 0;
    check({req, " stream valid"}, m_valid, 1);
    check({req, " stream data"}, m_data, dout);
  endtask

  task automatic t_reset;
    check("R11 done", done, 0);
    check("R11 status", status, 0);
    check("R11 corrected", corrected_cnt, 0);
    check("R11 failed", failed_cnt, 0);
    check("R11 max", max_flips, 0);
    check("R11 m_valid", m_valid, 0);
  endtask

  task automatic t_clean;
    issue(24'hA5C3F0, 24'hA5C3F0, 0);
    expect_result("R2 clean", 0, 0, 0);
    @(negedge clk);
    check("R9 done drops", done, 0);
  endtask

  task automatic t_data_fix;
    issue(pack(12'h123, 12'h456), pack(12'h123 ^ 12'hD4A, 12'h456 ^ 12'h2B5), 0);
    expect_result("R3 R1 data fix", 1, 86, 5);
    stream("R10 flip", 86, 8'h00, 8'h20);
    stream("R10 other byte", 85, 8'h3C, 8'h3C);
    stream("R10 flip ones", 86, 8'hFF, 8'hDF);
  endtask

  task automatic t_boundaries;
    issue(pack(12'h000, 12'hFFF), pack(12'h000, 12'h000), 0);
    expect_result("R3 top offset", 1, 511, 7);
    stream("R10 last byte", 511, 8'h01, 8'h81);
    issue(pack(12'hFFF, 12'h000), pack(12'h000, 12'h000), 0);
    expect_result("R3 zero offset", 1, 0, 0);
  endtask

  task automatic t_code_bit;
    issue(24'h000100, 24'h000000, 0);
    expect_result("R4 lower half bit", 2, 0, 0);
    stream("R4 no change", 0, 8'h5A, 8'h5A);
    issue(24'h001000, 24'h000000, 0);
    expect_result("R4 upper half bit", 2, 0, 0);
    issue(pack(12'h001, 12'h001), 24'h000000, 0);
    expect_result("R4 same bit both halves", 2, 0, 0);
  endtask

  task automatic t_uncorr;
    issue(24'h000003, 24'h000000, 0);
    expect_result("R5 two bits", 3, 0, 0);
    issue(pack(12'h0F0, 12'h00F), 24'h000000, 0);
    expect_result("R5 mixed", 3, 0, 0);
  endtask

  task automatic t_engine_failed;
    issue(24'h123456, 24'h123456, 1);
    expect_result("R6 engine failed", 3, 0, 0);
  endtask

  task automatic t_page;
    @(negedge clk);
    page_start = 1;
    @(negedge clk);
    page_start = 0;
    exp_corr = 0; exp_fail = 0; exp_max = 0;
    check("R8 clear corrected", corrected_cnt, 0);
    check("R8 clear failed", failed_cnt, 0);
    check("R8 clear max", max_flips, 0);
    @(negedge clk);
    page_start = 1; start = 1; stored_ecc = 24'h000001; calc_ecc = 24'h0;
    @(negedge clk);
    page_start = 0; start = 0;
    expect_result("R8 page with chunk", 2, 0, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    stored_ecc = 24'h777777; calc_ecc = 24'h777777; start = 1;
    @(negedge clk);
    check("R9 first done", done, 1);
    check("R9 first status", status, 0);
    stored_ecc = 24'h000007; calc_ecc = 24'h0;
    @(negedge clk);
    start = 0;
    exp_fail++;
    check("R9 second done", done, 1);
    check("R9 second status", status, 3);
    check("R5 failed after pair", failed_cnt, exp_fail);
    @(negedge clk);
    check("R9 done low", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_clean;
    t_data_fix;
    t_boundaries;
    t_code_bit;
    t_uncorr;
    t_engine_failed;
    t_page;
    t_back_to_back;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule